// File: doc/BRIEF.md
# SD Host Error Interrupt Status Register

This block collects the error events of an SD/SDIO host controller into one 16-bit sticky status word and raises a single interrupt line from it. The command-line, data-line, DMA, tuning and power-monitor logic each send a one-cycle error pulse. The auto-command engine instead presents a 5-bit error vector, and the block watches that vector for any bit that turns on. Each event is qualified by a per-bit status-enable mask before it can latch. A second per-bit signal-enable mask decides which latched bits reach the interrupt output.

Software reaches three words over a simple register bus: the status word, the status-enable mask and the signal-enable mask. Software clears a status bit by writing 1 to it. The command-CRC and command-timeout bits latch independently, so a reader can tell all four outcomes of a command apart: no error, a timeout, a CRC error, or both together, which marks a command-line conflict.

Top module: `sd_err_irq_status`

## Requirements
- R1: After reset, the status word, both masks and `irq` are all 0.
- R2: An event latches into its status bit at the clock edge that samples it, but only when the matching status-enable bit is 1. With that enable bit at 0, the status bit stays 0.
- R3: Writing to address 0 clears every status bit whose `wr_data` bit is 1. Status bits whose `wr_data` bit is 0 keep their value.
- R4: If a set event and a write-1 clear reach the same status bit in the same cycle, the bit ends up 1.
- R5: Status bit 8 sets when any bit of `acmd_err[4:0]` goes from 0 to 1 between two consecutive clock samples. A bit that stays high does not set it, and neither does a bit that falls.
- R6: `irq` equals the OR over all bits of (status AND signal-enable), registered, so it follows a change of status or mask one clock later.
- R7: Address 0 reads the status word, address 1 the status-enable mask and address 2 the signal-enable mask. Both masks are full 16-bit read/write. Status bits 15:11 and address 3 always read 0.
- R8: Status bit positions: 0 command timeout, 1 command CRC, 2 command end bit, 3 command index, 4 data timeout, 5 data CRC, 6 data end bit, 7 current limit, 8 auto-command, 9 DMA, 10 tuning. Events `err_evt[7:0]` drive bits 7:0, `err_evt[8]` drives bit 9 and `err_evt[9]` drives bit 10.
- R9: Bits 0 and 1 latch independently, so that any of the combinations 00, 01, 10 and 11 (11 meaning a command-line conflict) can be read back.
- R10: A latched status bit stays 1 after its event goes away, until software clears it.
- R11: Clearing a status-enable bit neither clears the status bit already latched nor lets a later event set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rd_data` is 0 when low |
| addr | input | 2 | Register address (0 status, 1 status-enable, 2 signal-enable) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data |
| err_evt | input | 10 | Error event pulses, mapped as in R8 |
| acmd_err | input | 5 | Auto-command error vector, edge detected |
| irq | output | 1 | Registered error interrupt |

## Verification
Properties checked on every clock edge:
- No status bit rises without its status-enable bit.
- A set always beats a concurrent clear.
- A written 1 removes a bit unless that bit is being set in the same cycle.
- Latched bits never drop on their own.
- `irq` tracks the registered masked OR.
- The reserved status bits read 0.

Some behaviour can only be shown by the bench's scenarios: the exact mapping of each event input to its bit position, the edge detection on the auto-command vector (held and falling bits must not set it), the readback of both masks and of the unused address, and the four command-bit combinations.

// File: rtl/sd_eis_pkg.sv
package sd_eis_pkg;

   // Register addresses on the bus
   localparam int unsigned EIS_ADDR_STATUS = 0;
   localparam int unsigned EIS_ADDR_STAT_EN = 1;
   localparam int unsigned EIS_ADDR_SIG_EN = 2;

   // Status bit positions
   localparam int unsigned EIS_BIT_CMD_TMO = 0;
   localparam int unsigned EIS_BIT_CMD_CRC = 1;
   localparam int unsigned EIS_BIT_CMD_END = 2;
   localparam int unsigned EIS_BIT_CMD_IDX = 3;
   localparam int unsigned EIS_BIT_DAT_TMO = 4;
   localparam int unsigned EIS_BIT_DAT_CRC = 5;
   localparam int unsigned EIS_BIT_DAT_END = 6;
   localparam int unsigned EIS_BIT_PWR_LIM = 7;
   localparam int unsigned EIS_BIT_AUTOCMD = 8;
   localparam int unsigned EIS_BIT_DMA = 9;
   localparam int unsigned EIS_BIT_TUNE = 10;

   // Event input index that feeds a given status bit (the auto-command bit has none)
   function automatic int unsigned eis_evt_index(input int unsigned bit_pos,
                                                 input int unsigned acmd_pos);
      return (bit_pos < acmd_pos) ? bit_pos : bit_pos - 1;
   endfunction

endpackage

// File: rtl/sd_eis_acmd_edge.sv
module sd_eis_acmd_edge #(
   parameter int unsigned ACMD_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ACMD_W-1:0] vec_i,
   output logic              rise_o
);

   logic [ACMD_W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
      end else begin
         prev_q <= vec_i;
      end
   end

   // Any bit that is now high but was low one sample ago
   assign rise_o = |(vec_i & ~prev_q);

endmodule

// File: rtl/sd_eis_status_bits.sv
module sd_eis_status_bits #(
   parameter int unsigned STAT_BITS = 11,
   parameter int unsigned NUM_EVT   = 10,
   parameter int unsigned ACMD_BIT  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_EVT-1:0]   evt_i,
   input  logic                 acmd_rise_i,
   input  logic [STAT_BITS-1:0] stat_en_i,
   input  logic [STAT_BITS-1:0] clr_i,
   output logic [STAT_BITS-1:0] set_o,
   output logic [STAT_BITS-1:0] status_o
);
   import sd_eis_pkg::*;

   if (NUM_EVT + 1 != STAT_BITS) begin : g_bad_evt
      $error("sd_eis_status_bits: NUM_EVT must equal STAT_BITS-1");
   end

   for (genvar b = 0; b < STAT_BITS; b++) begin : g_bit
      logic raw;
      logic q;

      if (b == ACMD_BIT) begin : g_src_acmd
         assign raw = acmd_rise_i;
      end else begin : g_src_evt
         localparam int unsigned EI = eis_evt_index(b, ACMD_BIT);
         assign raw = evt_i[EI];
      end

      assign set_o[b] = raw & stat_en_i[b];

      // A set in the same cycle as a clear wins
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= 1'b0;
         end else begin
            q <= (q & ~clr_i[b]) | set_o[b];
         end
      end

      assign status_o[b] = q;
   end

endmodule

// File: rtl/sd_eis_irq_gen.sv
module sd_eis_irq_gen #(
   parameter int unsigned STAT_BITS = 11,
   parameter bit          IRQ_REG   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [STAT_BITS-1:0] status_i,
   input  logic [STAT_BITS-1:0] sig_en_i,
   output logic                 irq_o
);

   logic any_hit;

   assign any_hit = |(status_i & sig_en_i);

   if (IRQ_REG) begin : g_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q <= 1'b0;
         end else begin
            irq_q <= any_hit;
         end
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      assign irq_o = any_hit;
   end

endmodule

// File: rtl/sd_err_irq_status.sv
module sd_err_irq_status #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned STAT_BITS = 11,
   parameter int unsigned ACMD_W    = 5,
   parameter int unsigned ACMD_BIT  = 8,
   parameter bit          IRQ_REG   = 1'b1,
   localparam int unsigned NUM_EVT  = STAT_BITS - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [NUM_EVT-1:0] err_evt,
   input  logic [ACMD_W-1:0]  acmd_err,
   output logic               irq
);
   import sd_eis_pkg::*;

   // Elaboration-time parameter checks
   if (STAT_BITS > DATA_W) begin : g_bad_width
      $error("sd_err_irq_status: STAT_BITS exceeds DATA_W");
   end
   if (ACMD_BIT >= STAT_BITS) begin : g_bad_acmd
      $error("sd_err_irq_status: ACMD_BIT outside the status word");
   end
   if (STAT_BITS < 2) begin : g_bad_bits
      $error("sd_err_irq_status: at least two status bits required");
   end
   if ((1 << ADDR_W) <= EIS_ADDR_SIG_EN) begin : g_bad_addr
      $error("sd_err_irq_status: ADDR_W too small for the register set");
   end

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(EIS_ADDR_STATUS);
   localparam logic [ADDR_W-1:0] A_STATEN = ADDR_W'(EIS_ADDR_STAT_EN);
   localparam logic [ADDR_W-1:0] A_SIGEN  = ADDR_W'(EIS_ADDR_SIG_EN);

   logic [DATA_W-1:0]    stat_en_q;
   logic [DATA_W-1:0]    sig_en_q;
   logic [STAT_BITS-1:0] status_q;
   logic [STAT_BITS-1:0] set_vec;
   logic [STAT_BITS-1:0] clr_vec;
   logic                 acmd_rise;
   logic                 wr_status;

   // Mask registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_en_q <= '0;
         sig_en_q  <= '0;
      end else if (wr_en) begin
         if (addr == A_STATEN) stat_en_q <= wr_data;
         if (addr == A_SIGEN)  sig_en_q  <= wr_data;
      end
   end

   // Write-1-to-clear strobe for the status word
   assign wr_status = wr_en && (addr == A_STATUS);
   assign clr_vec   = wr_status ? wr_data[STAT_BITS-1:0] : '0;

   sd_eis_acmd_edge #(
      .ACMD_W (ACMD_W)
   ) u_acmd_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .vec_i  (acmd_err),
      .rise_o (acmd_rise)
   );

   sd_eis_status_bits #(
      .STAT_BITS (STAT_BITS),
      .NUM_EVT   (NUM_EVT),
      .ACMD_BIT  (ACMD_BIT)
   ) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (err_evt),
      .acmd_rise_i (acmd_rise),
      .stat_en_i   (stat_en_q[STAT_BITS-1:0]),
      .clr_i       (clr_vec),
      .set_o       (set_vec),
      .status_o    (status_q)
   );

   sd_eis_irq_gen #(
      .STAT_BITS (STAT_BITS),
      .IRQ_REG   (IRQ_REG)
   ) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_q),
      .sig_en_i (sig_en_q[STAT_BITS-1:0]),
      .irq_o    (irq)
   );

   // Read mux; unimplemented status bits and unused addresses read 0
   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         case (addr)
            A_STATUS: rd_data = DATA_W'(status_q);
            A_STATEN: rd_data = stat_en_q;
            A_SIGEN:  rd_data = sig_en_q;
            default:  rd_data = '0;
         endcase
      end
   end

endmodule

// File: rtl/sd_eis_checker.sv
module sd_eis_checker #(
   parameter int unsigned STAT_BITS = 11,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 2,
   parameter bit          IRQ_REG   = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [STAT_BITS-1:0] status,
   input logic [STAT_BITS-1:0] set_vec,
   input logic [STAT_BITS-1:0] clr_vec,
   input logic [DATA_W-1:0]    stat_en,
   input logic [DATA_W-1:0]    sig_en,
   input logic [DATA_W-1:0]    rd_data,
   input logic                 rd_en,
   input logic [ADDR_W-1:0]    addr,
   input logic                 irq
);

   // R2
   no_set_without_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~$past(status) & ~$past(stat_en[STAT_BITS-1:0])) == '0);

   // R4
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(set_vec) & ~status) == '0);

   // R3
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status & $past(clr_vec) & ~$past(set_vec)) == '0);

   // R10
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status) & ~status & ~$past(clr_vec)) == '0);

   if (IRQ_REG) begin : g_irq_reg
      // R6
      irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq == $past(|(status & sig_en[STAT_BITS-1:0])));
   end else begin : g_irq_comb
      // R6
      irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq == |(status & sig_en[STAT_BITS-1:0]));
   end

   if (STAT_BITS < DATA_W) begin : g_rsvd
      // R7
      reserved_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && addr == '0) |-> (rd_data[DATA_W-1:STAT_BITS] == '0));
   end

endmodule

bind sd_err_irq_status sd_eis_checker #(
   .STAT_BITS (STAT_BITS),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .IRQ_REG   (IRQ_REG)
) u_eis_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .status  (status_q),
   .set_vec (set_vec),
   .clr_vec (clr_vec),
   .stat_en (stat_en_q),
   .sig_en  (sig_en_q),
   .rd_data (rd_data),
   .rd_en   (rd_en),
   .addr    (addr),
   .irq     (irq)
);

// File: tb/tb_sd_err_irq_status.sv
module tb_sd_err_irq_status;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [9:0]  err_evt = '0;
   logic [4:0]  acmd_err = '0;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;   // 250 MHz

   sd_err_irq_status dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .err_evt  (err_evt),
      .acmd_err (acmd_err),
      .irq      (irq)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=0x%04h expected=0x%04h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse_evt(input logic [9:0] v);
      @(negedge clk);
      err_evt = v;
      @(negedge clk);
      err_evt = '0;
   endtask

   task automatic set_acmd(input logic [4:0] v);
      @(negedge clk);
      acmd_err = v;
      @(negedge clk);
   endtask

   // Raise the event source behind status bit b (R8 mapping)
   task automatic trig(input int b);
      if (b == 8) begin
         set_acmd(5'b00100);
         set_acmd(5'b00000);
      end else begin
         pulse_evt(10'(1 << ((b < 8) ? b : b - 1)));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [15:0] m;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, v); chk("R1 status", v, 16'h0000);
      rd(2'd1, v); chk("R1 stat_en", v, 16'h0000);
      rd(2'd2, v); chk("R1 sig_en", v, 16'h0000);
      chk("R1 irq", {15'd0, irq}, 16'h0000);

      // R7 mask readback and unused address
      wr(2'd1, 16'hFFFF); rd(2'd1, v); chk("R7 stat_en rw", v, 16'hFFFF);
      wr(2'd2, 16'hA5A5); rd(2'd2, v); chk("R7 sig_en rw", v, 16'hA5A5);
      rd(2'd3, v); chk("R7 addr3 zero", v, 16'h0000);
      wr(2'd2, 16'h0000);

      // R2 / R8 / R10 / R3 / R6 sweep over all status bits and enable values
      for (int b = 0; b < 11; b++) begin
         for (int en = 0; en < 2; en++) begin
            m = 16'(1 << b);
            wr(2'd1, en ? m : ~m);
            trig(b);
            rd(2'd0, v);
            chk(en ? "R2 R8 enabled set" : "R2 disabled no-set", v, en ? m : 16'h0000);
            if (en) begin
               repeat (3) tick();
               rd(2'd0, v); chk("R10 sticky", v, m);
               wr(2'd0, 16'h0000); rd(2'd0, v); chk("R3 write0 keeps", v, m);
               wr(2'd0, ~m); rd(2'd0, v); chk("R3 other bits keep", v, m);
               wr(2'd2, m);
               chk("R6 irq latency", {15'd0, irq}, 16'h0000);
               tick();
               chk("R6 irq on", {15'd0, irq}, 16'h0001);
               wr(2'd2, ~m); tick();
               chk("R6 irq masked", {15'd0, irq}, 16'h0000);
               wr(2'd2, 16'h0000);
               wr(2'd0, m); rd(2'd0, v); chk("R3 w1c clears", v, 16'h0000);
            end
         end
      end

      // R7 reserved bits with all events at once
      wr(2'd1, 16'hFFFF);
      @(negedge clk);
      err_evt = 10'h3FF; acmd_err = 5'b11111;
      @(negedge clk);
      err_evt = '0; acmd_err = '0;
      rd(2'd0, v); chk("R7 reserved zero", v, 16'h07FF);
      wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R3 clear all", v, 16'h0000);

      // R4 set wins over a simultaneous clear; R3 other bit cleared in the same write
      pulse_evt(10'h004);
      @(negedge clk);
      err_evt = 10'h010; wr_en = 1'b1; addr = 2'd0; wr_data = 16'h0014;
      @(negedge clk);
      err_evt = '0; wr_en = 1'b0; wr_data = '0;
      rd(2'd0, v); chk("R4 set beats clear", v, 16'h0010);
      wr(2'd0, 16'hFFFF);

      // R5 auto-command edge detection
      set_acmd(5'b00001); rd(2'd0, v); chk("R5 rise sets", v, 16'h0100);
      wr(2'd0, 16'h0100);
      repeat (3) tick();
      rd(2'd0, v); chk("R5 held no set", v, 16'h0000);
      set_acmd(5'b00011); rd(2'd0, v); chk("R5 second bit rise", v, 16'h0100);
      wr(2'd0, 16'h0100);
      set_acmd(5'b00010); rd(2'd0, v); chk("R5 fall no set", v, 16'h0000);
      set_acmd(5'b00000); rd(2'd0, v); chk("R5 all low no set", v, 16'h0000);
      for (int k = 0; k < 5; k++) begin
         set_acmd(5'(1 << k));
         rd(2'd0, v); chk("R5 per-bit rise", v, 16'h0100);
         set_acmd(5'b00000);
         wr(2'd0, 16'h0100);
      end

      // R9 command bit pair combinations
      pulse_evt(10'h003); rd(2'd0, v); chk("R9 conflict 11", v, 16'h0003);
      wr(2'd0, 16'h0003);
      pulse_evt(10'h002); rd(2'd0, v); chk("R9 crc 10", v, 16'h0002);
      wr(2'd0, 16'h0003);
      pulse_evt(10'h001); rd(2'd0, v); chk("R9 timeout 01", v, 16'h0001);
      wr(2'd0, 16'h0003);

      // R11 disabling the status enable keeps latched bits and blocks new ones
      pulse_evt(10'h020);
      wr(2'd1, 16'h0000);
      rd(2'd0, v); chk("R11 kept after disable", v, 16'h0020);
      pulse_evt(10'h3FF);
      rd(2'd0, v); chk("R11 blocked after disable", v, 16'h0020);

      // R6 multiple bits, mask picks one, clear drops irq one cycle later
      wr(2'd1, 16'hFFFF);
      pulse_evt(10'h001);
      wr(2'd2, 16'h0020); tick();
      chk("R6 masked-in bit", {15'd0, irq}, 16'h0001);
      wr(2'd0, 16'h0020);
      chk("R6 still high before update", {15'd0, irq}, 16'h0001);
      tick();
      chk("R6 drops after clear", {15'd0, irq}, 16'h0000);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule